// File: doc/BRIEF.md
# Keyboard Controller Output Port

This block keeps the 8-bit output port of a keyboard controller. The port drives two system-level lines: the A20 address gate and the system reset request. A command parser upstream forwards every byte written to the command register as a one-cycle `cmd_valid` strobe. It forwards every byte written to the data register as a one-cycle `data_valid` strobe. The block acts on the opcodes that concern the port and lets all other opcodes pass with no effect.

Software can reach the port in three ways:
- A two-step full write: command 0xD1 arms the port, and the next data byte becomes the new port value.
- Single-bit A20 commands.
- The pulse family 0xF0 to 0xFF. In a pulse command, a clear bit 0 means "pulse the reset line". Every other pattern in that family does nothing.

The reset request is stretched to a programmable number of clocks. This stands in for the short low pulse on a real reset pin.

Bits 4 and 5 of the visible port do not come from storage. They follow the keyboard and mouse output-buffer-full flags that the buffer arbiter supplies. The visible value is what a port read-back command returns to the host.

Top module: `kbc_outport`

## Requirements
- R1: After reset the stored port is 0xCF. With both full flags low, `port_value` reads 0xCF, `a20_o` is 1 and `sys_rst_req` is 0.
- R2: After command 0xD1, the next data byte is stored in the port on the clock edge that accepts it. From the following cycle, `port_value` shows that byte with bits 4 and 5 replaced by the live flags, and `a20_o` equals the byte's bit 1.
- R3: An accepted port write whose bit 0 is 0 raises `sys_rst_req` in the next cycle and holds it for RST_HOLD cycles. An accepted write with bit 0 set raises no request.
- R4: Command 0xDF sets port bit 1 and drives `a20_o` high. Command 0xDD clears bit 1 and drives `a20_o` low. All other stored bits are unchanged.
- R5: A command whose upper nibble is 0xF and whose bit 0 is 0 raises `sys_rst_req` for RST_HOLD cycles. Such a command with bit 0 set does nothing. No pulse command changes the stored port.
- R6: `port_value` bit 4 equals `kbd_full` and bit 5 equals `aux_full` in the same cycle, whatever was stored in those positions.
- R7: A data byte that arrives while the port is not armed is ignored. An arm is used up by exactly one data byte.
- R8: An armed port write is cancelled by any other command that claims the next data byte (0x60, 0xD2, 0xD3, 0xD4). Commands that claim no data byte, such as 0xD0 and 0xDF, leave it armed.
- R9: A new reset trigger while `sys_rst_req` is high restarts the hold, so the request stays high for RST_HOLD cycles after the latest trigger.
- R10: Opcodes outside the port set (for example 0xA8, 0xAD, 0xD0) change neither the port nor `sys_rst_req`.
- R11: When a command and a data byte arrive in the same cycle, the data byte is applied first, using the arm state from before that cycle. The command then acts on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a command byte was written |
| cmd_byte | input | 8 | Command opcode |
| data_valid | input | 1 | One-cycle strobe: a data byte was written |
| data_byte | input | 8 | Data byte |
| kbd_full | input | 1 | Keyboard output-buffer-full flag from the arbiter |
| aux_full | input | 1 | Mouse output-buffer-full flag from the arbiter |
| port_value | output | 8 | Visible port value used for read-back |
| a20_o | output | 1 | A20 gate level |
| sys_rst_req | output | 1 | System reset request, held RST_HOLD cycles |

## Verification
On every cycle, the assertions check the following:
- Each A20 command and each accepted port write is followed by the matching `a20_o` level.
- A low-bit-0 pulse command is followed by a reset request.
- Every rising edge of the request has a trigger behind it.
- The request never lasts longer than RST_HOLD cycles after its latest trigger.
- Unrelated opcodes leave the stored bits alone.

Only the bench scenarios can show the rest:
- An arm is kept across harmless commands and dropped by competing ones.
- A stray data byte is ignored.
- The live flags override stored bits 4 and 5.
- A request is released on the exact cycle it should end.
- Same-cycle command and data follow the stated ordering.

// File: rtl/kbc_outport_pkg.sv
package kbc_outport_pkg;

  localparam int PORT_W = 8;

  // Opcodes the port logic reacts to
  localparam logic [7:0] OP_MODE_WRITE     = 8'h60;
  localparam logic [7:0] OP_PORT_READ      = 8'hD0;
  localparam logic [7:0] OP_PORT_WRITE     = 8'hD1;
  localparam logic [7:0] OP_OBUF_WRITE     = 8'hD2;
  localparam logic [7:0] OP_AUX_OBUF_WRITE = 8'hD3;
  localparam logic [7:0] OP_AUX_SEND       = 8'hD4;
  localparam logic [7:0] OP_GATE_OFF       = 8'hDD;
  localparam logic [7:0] OP_GATE_ON        = 8'hDF;
  localparam logic [3:0] PULSE_NIBBLE      = 4'hF;

  // Port layout
  localparam logic [PORT_W-1:0] PORT_RESET = 8'hCF;
  localparam int PB_RUN   = 0;
  localparam int PB_GATE  = 1;
  localparam int PB_KFULL = 4;
  localparam int PB_AFULL = 5;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ARM,
    ACT_DISARM,
    ACT_GATE_ON,
    ACT_GATE_OFF,
    ACT_PULSE_RST
  } act_e;

  function automatic logic is_pulse_family(input logic [7:0] op);
    return op[7:4] == PULSE_NIBBLE;
  endfunction

  // 0 in a pulse-mask bit means "pulse"; only bit 0 (reset line) matters
  function automatic logic pulse_hits_run(input logic [7:0] op);
    return is_pulse_family(op) && !op[PB_RUN];
  endfunction

  function automatic act_e classify(input logic [7:0] op);
    act_e a;
    if (pulse_hits_run(op)) a = ACT_PULSE_RST;
    else if (is_pulse_family(op)) a = ACT_NONE;
    else begin
      unique case (op)
        OP_PORT_WRITE:                    a = ACT_ARM;
        OP_MODE_WRITE, OP_OBUF_WRITE,
        OP_AUX_OBUF_WRITE, OP_AUX_SEND:   a = ACT_DISARM;
        OP_GATE_ON:                       a = ACT_GATE_ON;
        OP_GATE_OFF:                      a = ACT_GATE_OFF;
        default:                          a = ACT_NONE;
      endcase
    end
    return a;
  endfunction

  // Visible port: stored bits with the two live buffer-full mirrors
  function automatic logic [PORT_W-1:0] merge_mirrors(input logic [PORT_W-1:0] stored,
                                                      input logic kf, input logic af);
    logic [PORT_W-1:0] v;
    v = stored;
    v[PB_KFULL] = kf;
    v[PB_AFULL] = af;
    return v;
  endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_outport_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output act_e       act
);
  always_comb begin
    act = ACT_NONE;
    if (cmd_valid) act = classify(cmd_byte);
  end
endmodule

// File: rtl/kbc_port_reg.sv
module kbc_port_reg
  import kbc_outport_pkg::*;
#(
  parameter int W = PORT_W,
  parameter logic [W-1:0] RESET_VAL = PORT_RESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  act_e         act,
  input  logic         data_valid,
  input  logic [W-1:0] data_byte,
  output logic [W-1:0] stored,
  output logic         armed,
  output logic         wr_fire
);
  logic [W-1:0] stored_nx;
  logic         armed_nx;
  logic         take_data;

  assign take_data = data_valid && armed;
  assign wr_fire   = take_data && !data_byte[PB_RUN];

  // Data byte is applied first, then the command acts on the result
  always_comb begin
    stored_nx = stored;
    armed_nx  = armed;
    if (data_valid) begin
      armed_nx = 1'b0;
      if (armed) stored_nx = data_byte;
    end
    unique case (act)
      ACT_ARM:      armed_nx = 1'b1;
      ACT_DISARM:   armed_nx = 1'b0;
      ACT_GATE_ON:  stored_nx[PB_GATE] = 1'b1;
      ACT_GATE_OFF: stored_nx[PB_GATE] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored <= RESET_VAL;
      armed  <= 1'b0;
    end else begin
      stored <= stored_nx;
      armed  <= armed_nx;
    end
  end
endmodule

// File: rtl/kbc_rst_stretch.sv
module kbc_rst_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  generate
    if (HOLD <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= fire;
      end
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (fire)       cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign req = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
  import kbc_outport_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       data_valid,
  input  logic [7:0] data_byte,
  input  logic       kbd_full,
  input  logic       aux_full,
  output logic [7:0] port_value,
  output logic       a20_o,
  output logic       sys_rst_req
);
  act_e              act_w;
  logic [PORT_W-1:0] stored_w;
  logic              armed_w;
  logic              wr_fire_w;
  logic              pulse_fire_w;
  logic              rst_fire_w;

  kbc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .act       (act_w)
  );

  kbc_port_reg #(.W(PORT_W), .RESET_VAL(PORT_RESET)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act_w),
    .data_valid (data_valid),
    .data_byte  (data_byte),
    .stored     (stored_w),
    .armed      (armed_w),
    .wr_fire    (wr_fire_w)
  );

  assign pulse_fire_w = (act_w == ACT_PULSE_RST);
  assign rst_fire_w   = pulse_fire_w || wr_fire_w;

  kbc_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (rst_fire_w),
    .req   (sys_rst_req)
  );

  assign port_value = merge_mirrors(stored_w, kbd_full, aux_full);
  assign a20_o      = stored_w[PB_GATE];
endmodule

// File: rtl/kbc_outport_chk.sv
module kbc_outport_chk
  import kbc_outport_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       data_valid,
  input logic [7:0] data_byte,
  input logic [7:0] port_value,
  input logic       a20_o,
  input logic       sys_rst_req,
  input logic       armed,
  input logic       rst_fire,
  input act_e       act
);
  localparam int HW = $clog2(RST_HOLD + 2) + 1;
  logic [HW-1:0] high_run;

  always_ff @(posedge clk) begin
    if (!rst_n)           high_run <= '0;
    else if (rst_fire)    high_run <= '0;
    else if (sys_rst_req) high_run <= high_run + 1'b1;
    else                  high_run <= '0;
  end

  AST_GATE_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte == OP_GATE_ON |=> a20_o); // R4
  AST_GATE_OFF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte == OP_GATE_OFF |=> !a20_o); // R4
  AST_WRITE_SETS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid && armed && !cmd_valid |=> a20_o == $past(data_byte[PB_GATE])); // R2
  AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte[7:4] == PULSE_NIBBLE && !cmd_byte[0] |=> sys_rst_req); // R5
  AST_PULSE_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_byte[7:4] == PULSE_NIBBLE && !data_valid
    |=> $stable({port_value[7:6], port_value[3:0]})); // R5
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(rst_fire)); // R3
  AST_REQ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> high_run < HW'(RST_HOLD)); // R9
  AST_OTHER_OPS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && act == ACT_NONE && !data_valid
    |=> $stable({port_value[7:6], port_value[3:0]})); // R10
endmodule

bind kbc_outport kbc_outport_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_byte    (cmd_byte),
  .data_valid  (data_valid),
  .data_byte   (data_byte),
  .port_value  (port_value),
  .a20_o       (a20_o),
  .sys_rst_req (sys_rst_req),
  .armed       (armed_w),
  .rst_fire    (rst_fire_w),
  .act         (act_w)
);

// File: tb/sim_kbc_outport.sv
`timescale 1ns/1ps
module sim_kbc_outport;
  localparam int HOLD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       data_valid = 1'b0;
  logic [7:0] data_byte = 8'h00;
  logic       kbd_full = 1'b0;
  logic       aux_full = 1'b0;
  logic [7:0] port_value;
  logic       a20_o;
  logic       sys_rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbc_outport #(.RST_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte),
    .kbd_full(kbd_full), .aux_full(aux_full),
    .port_value(port_value), .a20_o(a20_o), .sys_rst_req(sys_rst_req)
  );

  typedef struct packed {
    logic       cv;
    logic [7:0] cb;
    logic       dv;
    logic [7:0] db;
    logic       kf;
    logic       af;
    logic [7:0] ep;
    logic       ea;
    logic       er;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 39;
  // cv cb dv db kf af | expected port a20 req | requirement
  localparam vec_t VECS [NV] = '{
    '{1'b1,8'hDD,1'b0,8'h00,1'b0,1'b0, 8'hCD,1'b0,1'b0, 8'd4},  // R4 gate off
    '{1'b1,8'hDF,1'b0,8'h00,1'b0,1'b0, 8'hCF,1'b1,1'b0, 8'd4},  // R4 gate on
    '{1'b0,8'h00,1'b0,8'h00,1'b1,1'b0, 8'hDF,1'b1,1'b0, 8'd6},  // R6 kbd mirror
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b1, 8'hEF,1'b1,1'b0, 8'd6},  // R6 aux mirror
    '{1'b0,8'h00,1'b0,8'h00,1'b1,1'b1, 8'hFF,1'b1,1'b0, 8'd6},  // R6 both
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'hCF,1'b1,1'b0, 8'd2},  // R2 arm
    '{1'b0,8'h00,1'b1,8'h33,1'b0,1'b0, 8'h03,1'b1,1'b0, 8'd2},  // R2 write, R6 stored 4/5 hidden
    '{1'b0,8'h00,1'b0,8'h00,1'b1,1'b0, 8'h13,1'b1,1'b0, 8'd6},  // R6
    '{1'b0,8'h00,1'b1,8'h00,1'b0,1'b0, 8'h03,1'b1,1'b0, 8'd7},  // R7 unarmed data
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'h03,1'b1,1'b0, 8'd2},
    '{1'b1,8'hD0,1'b0,8'h00,1'b0,1'b0, 8'h03,1'b1,1'b0, 8'd8},  // R8 read keeps arm
    '{1'b0,8'h00,1'b1,8'hFC,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd3},  // R3 bit0 low
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd3},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd3},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd3},  // R3 released
    '{1'b1,8'hF1,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd5},  // R5 no-op pulse
    '{1'b1,8'hFE,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd5},  // R5 reset pulse
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd5},
    '{1'b1,8'hF0,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd9},  // R9 retrigger
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd9},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b1, 8'd9},
    '{1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd9},  // R9 release
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},
    '{1'b1,8'h60,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},  // R8 cancel
    '{1'b0,8'h00,1'b1,8'hFF,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},
    '{1'b1,8'hD2,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},
    '{1'b0,8'h00,1'b1,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd8},
    '{1'b1,8'hA8,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd10}, // R10
    '{1'b1,8'hAD,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd10},
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'hCC,1'b0,1'b0, 8'd2},
    '{1'b0,8'h00,1'b1,8'hCF,1'b0,1'b0, 8'hCF,1'b1,1'b0, 8'd2},
    '{1'b0,8'h00,1'b1,8'h00,1'b0,1'b0, 8'hCF,1'b1,1'b0, 8'd7},  // R7 arm used up
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'hCF,1'b1,1'b0, 8'd11},
    '{1'b1,8'hDD,1'b1,8'h0F,1'b0,1'b0, 8'h0D,1'b0,1'b0, 8'd11}, // R11 data then cmd
    '{1'b1,8'hDF,1'b0,8'h00,1'b0,1'b0, 8'h0F,1'b1,1'b0, 8'd4},
    '{1'b1,8'hD1,1'b0,8'h00,1'b0,1'b0, 8'h0F,1'b1,1'b0, 8'd8},
    '{1'b1,8'hD4,1'b0,8'h00,1'b0,1'b0, 8'h0F,1'b1,1'b0, 8'd8},
    '{1'b0,8'h00,1'b1,8'h00,1'b0,1'b0, 8'h0F,1'b1,1'b0, 8'd8}
  };

  task automatic check(input string tag, input logic [7:0] ep, input logic ea, input logic er);
    checks++;
    if (port_value !== ep || a20_o !== ea || sys_rst_req !== er) begin
      failures++;
      $display("FAIL %s: port=%02h a20=%0b req=%0b expected port=%02h a20=%0b req=%0b",
               tag, port_value, a20_o, sys_rst_req, ep, ea, er);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 1'b0; cmd_byte = 8'h00; data_valid = 1'b0; data_byte = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset state", 8'hCF, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_valid = VECS[i].cv; cmd_byte = VECS[i].cb;
      data_valid = VECS[i].dv; data_byte = VECS[i].db;
      kbd_full = VECS[i].kf; aux_full = VECS[i].af;
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].ep, VECS[i].ea, VECS[i].er);
    end

    // R3: write with bit0 set raises no request
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = 8'hD1; data_valid = 1'b0;
    @(negedge clk); cmd_valid = 1'b0; data_valid = 1'b1; data_byte = 8'hC9;
    @(posedge clk); #1;
    check("R3 bit0 high write", 8'hC9, 1'b0, 1'b0);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    check("R3 still no request", 8'hC9, 1'b0, 1'b0);

    // R1: reset during an active request returns to the reset state
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = 8'hFE;
    @(posedge clk); #1;
    check("R5 request before reset", 8'hC9, 1'b0, 1'b1);
    @(negedge clk); idle_inputs(); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 mid-run reset", 8'hCF, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); data_valid = 1'b1; data_byte = 8'h00;
    @(posedge clk); #1;
    check("R7 reset clears arm", 8'hCF, 1'b1, 1'b0);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    finish_run();
  end
endmodule